// File: doc/BRIEF.md
# Byte Transmit Framer with 8-to-10 Recoding

This block takes one byte at a time from a simple write strobe, recodes it into a 10-bit symbol and sends it out as a serial bit stream. The recoding splices the fixed group `0101` into the byte's low six bits. The top two data bits choose where the group goes. As a result, every data symbol carries a `0101` run that a receiver can use to keep its despreading code aligned.

The serial line advances only on cycles where a per-bit enable is high, so the bit rate is set outside the block. With nothing to send, the line alternates every bit time. A pending byte is framed by a marker of four ones, followed by its ten code bits, most significant first. The marker is only inserted after enough alternating bits have gone out and the line has just sent a one. A status word shows whether a byte is in flight and the state of a transmitter-enable bit, which drives a pin. Software can write only that enable bit.

Top module: `byte_framer`

## Requirements
- R1: After reset, `tx_data` is 0, `tx_enb` is 0 and `status` reads all zeros.
- R2: A byte `00abcdef` is sent as the ten bits `0101abcdef`.
- R3: A byte `01abcdef` is sent as the ten bits `a0101bcdef`.
- R4: A byte `10abcdef` is sent as the ten bits `ab0101cdef`.
- R5: A byte `11abcdef` is sent as the ten bits `abc0101def`.
- R6: While no frame is in progress, each bit time sends the inverse of the previous bit.
- R7: A frame begins only when the busy flag is set, at least IDLE_MIN (10) alternating bits have been sent since the last frame or reset, and the previous bit was a one. The frame then starts with START_LEN (4) consecutive ones.
- R8: The ten code bits follow the marker, most significant first. The next bit after them is the inverse of the last code bit, and the alternating-bit count restarts from that bit.
- R9: A `wr_en` pulse while not busy sets `status[7]` (busy) on the next cycle. Busy clears on the bit-enable edge that emits the tenth code bit.
- R10: A `wr_en` pulse while busy is ignored. The frame in flight is unchanged, and no second frame follows it.
- R11: `status[6]` and `tx_enb` follow bit 6 of the last `cfg_wr` write. Writing `cfg_data[7]` or any other bit does not change `status`, and `status[5:0]` always read 0.
- R12: `tx_data` changes only on clock edges where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per serial bit time |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| cfg_wr | input | 1 | Status register write strobe |
| cfg_data | input | STAT_W | Status write data; only bit 6 is used |
| status | output | STAT_W | {busy, enable, zeros} |
| tx_data | output | 1 | Serial output bit |
| tx_enb | output | 1 | Transmitter enable pin |

## Verification
Bytes are chosen from each of the four top-bit classes, so that a misplaced `0101` group or a swapped class selector shows up as a wrong bit at a known position. The payloads are all ones, all zeros and mixed. This separates a recoding error from a shift-order error. Frames are sent back to back, so the idle-count and last-bit gating of the marker is exercised right after a data symbol ends in either polarity. A write issued during a marker shows whether a busy write could replace the symbol or queue a ghost frame.

// File: rtl/txf_pkg.sv
package txf_pkg;
    localparam int DATA_W = 8;
    localparam int SYM_W  = 10;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2
    } phase_e;

    // Splice the 0101 group into the low six bits at a slot picked by the top two bits.
    function automatic logic [SYM_W-1:0] recode(input logic [DATA_W-1:0] d);
        logic [SYM_W-1:0] s;
        case (d[7:6])
            2'b00:   s = {4'b0101, d[5:0]};
            2'b01:   s = {d[5], 4'b0101, d[4:0]};
            2'b10:   s = {d[5:4], 4'b0101, d[3:0]};
            default: s = {d[5:3], 4'b0101, d[2:0]};
        endcase
        return s;
    endfunction
endpackage

// File: rtl/tx_encoder.sv
module tx_encoder
    import txf_pkg::*;
(
    input  logic [DATA_W-1:0] byte_in,
    output logic [SYM_W-1:0]  sym_out
);
    always_comb sym_out = recode(byte_in);
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
    import txf_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SYM_W-1:0]  sym_in,
    input  logic              cfg_wr,
    input  logic [STAT_W-1:0] cfg_data,
    input  logic              done,
    output logic              busy,
    output logic              enable,
    output logic [SYM_W-1:0]  sym
);
    localparam int EN_BIT = STAT_W - 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            enable <= 1'b0;
            sym    <= '0;
        end else begin
            if (cfg_wr) enable <= cfg_data[EN_BIT];
            if (done) begin
                busy <= 1'b0;
            end else if (wr_en && !busy) begin
                busy <= 1'b1;
                sym  <= sym_in;
            end
        end
    end

    // R10
    hold_sym_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> $stable(sym));
    // R9
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));
    // R9
    no_spurious_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !wr_en) |=> !busy);
    // R11
    en_write_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (enable == $past(cfg_data[EN_BIT])));
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import txf_pkg::*;
#(
    parameter int IDLE_MIN  = 10,
    parameter int START_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             busy,
    input  logic [SYM_W-1:0] sym,
    output logic             tx,
    output logic             done
);
    localparam int CMAX = (SYM_W > START_LEN) ? SYM_W : START_LEN;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int IW   = $clog2(IDLE_MIN + 1);

    phase_e           ph;
    logic [CW-1:0]    cnt;
    logic [IW-1:0]    idle_cnt;
    logic [SYM_W-1:0] sh;
    logic             go;

    always_comb begin
        go   = (ph == PH_IDLE) && busy && (idle_cnt == IW'(IDLE_MIN)) && tx;
        done = (ph == PH_DATA) && bit_en && (cnt == CW'(SYM_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            tx       <= 1'b0;
            cnt      <= '0;
            idle_cnt <= '0;
            sh       <= '0;
        end else if (bit_en) begin
            case (ph)
                PH_IDLE: begin
                    if (go) begin
                        tx  <= 1'b1;
                        cnt <= CW'(1);
                        ph  <= PH_START;
                    end else begin
                        tx <= ~tx;
                        if (idle_cnt != IW'(IDLE_MIN)) idle_cnt <= idle_cnt + 1'b1;
                    end
                end
                PH_START: begin
                    if (cnt == CW'(START_LEN)) begin
                        tx  <= sym[SYM_W-1];
                        sh  <= sym << 1;
                        cnt <= CW'(1);
                        ph  <= PH_DATA;
                    end else begin
                        tx  <= 1'b1;
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (cnt == CW'(SYM_W)) begin
                        tx       <= ~tx;
                        idle_cnt <= IW'(1);
                        cnt      <= '0;
                        ph       <= PH_IDLE;
                    end else begin
                        tx  <= sh[SYM_W-1];
                        sh  <= sh << 1;
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R12
    stable_out_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx));
    // R7
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_START && $past(ph) == PH_IDLE) |-> ($past(tx) && $past(busy)));
    // R7
    mark_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_START) |-> tx);
endmodule

// File: rtl/byte_framer.sv
module byte_framer
    import txf_pkg::*;
#(
    parameter int IDLE_MIN  = 10,
    parameter int START_LEN = 4,
    parameter int STAT_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              cfg_wr,
    input  logic [STAT_W-1:0] cfg_data,
    output logic [STAT_W-1:0] status,
    output logic              tx_data,
    output logic              tx_enb
);
    logic [SYM_W-1:0] enc_sym, held_sym;
    logic             busy, enable, done;

    tx_encoder u_enc (.byte_in(wr_data), .sym_out(enc_sym));

    tx_ctrl #(.STAT_W(STAT_W)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sym_in(enc_sym),
        .cfg_wr(cfg_wr), .cfg_data(cfg_data), .done(done),
        .busy(busy), .enable(enable), .sym(held_sym)
    );

    tx_serializer #(.IDLE_MIN(IDLE_MIN), .START_LEN(START_LEN)) u_ser (
        .clk(clk), .rst(rst), .bit_en(bit_en), .busy(busy), .sym(held_sym),
        .tx(tx_data), .done(done)
    );

    always_comb begin
        status = {busy, enable, {(STAT_W-2){1'b0}}};
        tx_enb = enable;
    end
endmodule

// File: tb/tb_byte_framer.sv
module tb_byte_framer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0, wr_en = 1'b0, cfg_wr = 1'b0;
    logic [7:0] wr_data = '0, cfg_data = '0;
    logic [7:0] status;
    logic       tx_data, tx_enb;

    int   total = 0, fails = 0, idle_seen = 0;
    logic last_bit = 1'b0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    byte_framer dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_wr(cfg_wr), .cfg_data(cfg_data), .status(status),
        .tx_data(tx_data), .tx_enb(tx_enb)
    );

    // {byte, expected 10-bit symbol}
    localparam logic [17:0] VEC [6] = '{
        {8'h2D, 10'b0101101101},
        {8'h00, 10'b0101000000},
        {8'h75, 10'b1010110101},
        {8'hB7, 10'b1101010111},
        {8'hC5, 10'b0000101101},
        {8'hFF, 10'b1110101111}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(output logic v);
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
        v = tx_data;
        @(negedge clk);
        chk(tx_data == v, "R12", tx_data, v);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk) begin wr_en = 1'b1; wr_data = b; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] c);
        @(negedge clk) begin cfg_wr = 1'b1; cfg_data = c; end
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    task automatic idle_run(input int n, input string req);
        logic v;
        for (int i = 0; i < n; i++) begin
            tick(v);
            chk(v == ~last_bit, req, v, ~last_bit);
            last_bit = ~last_bit;
            if (idle_seen < 10) idle_seen++;
        end
    endtask

    task automatic run_frame(input logic [7:0] b, input logic [9:0] code, input bit poke);
        string rq;
        logic  v;
        bit    started;
        int    guard;
        case (b[7:6])
            2'b00:   rq = "R2";
            2'b01:   rq = "R3";
            2'b10:   rq = "R4";
            default: rq = "R5";
        endcase
        started = 1'b0;
        guard = 0;
        chk(status[7] == 1'b0, "R9", status[7], 0);
        write_byte(b);
        chk(status[7] == 1'b1, "R9", status[7], 1);
        while (!started && guard < 40) begin
            guard++;
            tick(v);
            if (idle_seen >= 10 && last_bit) begin
                chk(v == 1'b1, "R7", v, 1);
                started = 1'b1;
            end else begin
                chk(v == ~last_bit, "R6", v, ~last_bit);
                last_bit = ~last_bit;
                if (idle_seen < 10) idle_seen++;
            end
        end
        if (!started) chk(1'b0, "R7", guard, 0);
        if (poke) write_byte(~b);   // R10: ignored while busy
        for (int i = 0; i < 3; i++) begin
            tick(v);
            chk(v == 1'b1, "R7", v, 1);
        end
        for (int i = 0; i < 10; i++) begin
            if (i == 9) chk(status[7] == 1'b1, "R9", status[7], 1);
            tick(v);
            chk(v == code[9-i], poke ? "R10" : rq, v, code[9-i]);
        end
        chk(status[7] == 1'b0, "R9", status[7], 0);
        last_bit = code[0];
        idle_seen = 0;
        tick(v);
        chk(v == ~last_bit, "R8", v, ~last_bit);
        last_bit = ~last_bit;
        idle_seen = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(tx_data == 1'b0, "R1", tx_data, 0);
        chk(status == 8'h00, "R1", status, 0);
        chk(tx_enb == 1'b0, "R1", tx_enb, 0);

        // R11: only bit 6 is writable
        write_cfg(8'hFF);
        chk(status == 8'h40, "R11", status, 8'h40);
        chk(tx_enb == 1'b1, "R11", tx_enb, 1);
        write_cfg(8'hBF);
        chk(status == 8'h00, "R11", status, 8'h00);
        chk(tx_enb == 1'b0, "R11", tx_enb, 0);
        write_cfg(8'h40);
        chk(status == 8'h40, "R11", status, 8'h40);

        // R6: idle alternation from reset
        idle_run(4, "R6");

        // Table walk: back-to-back frames (R2..R5, R7, R8, R9)
        for (int k = 0; k < 6; k++) run_frame(VEC[k][17:10], VEC[k][9:0], 1'b0);

        // R10: write during marker is ignored, no ghost frame follows
        run_frame(8'h2D, 10'b0101101101, 1'b1);
        idle_run(15, "R10");
        chk(status[7] == 1'b0, "R10", status[7], 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule